// File: doc/BRIEF.md
# PHY Management Register Sequencer

This block gives a host a single-command way to read or write a 16-bit PHY management register that sits behind a byte-wide register port of an Ethernet MAC. The PHY registers cannot be reached directly. Each access becomes a fixed series of 8-bit register operations on the MAC's MII management registers. The series sets the register address, starts the transaction, waits a settling time, polls a busy flag, and then either clears the command and collects two read bytes, or pushes two write bytes.

The host pulses `start` with a read/write select, a 5-bit PHY register number and 16-bit write data. The block drives a request/acknowledge register port towards the MAC (or towards an SPI bridge that reaches the MAC). When the series is over it pulses `done` for one cycle. For a read, the assembled word appears on `rd_data` in that same cycle. If the busy flag does not clear within a configurable number of polls, the block gives up and raises `err` together with `done`.

Top module: `mgmt_phy_seq`

## Requirements
- R1: After a synchronous active-low reset, `done`, `err` and `reg_req` are 0 and `rd_data` is 0x0000.
- R2: A read issues, in this order: a write of the PHY register number (zero-extended) to the address register; a write of 0x01 to the command register; status reads until the busy bit is 0; a write of 0x00 to the command register; a read of the high read-data register; a read of the low read-data register.
- R3: In a read, exactly WAIT_CYC = CLK_MHZ * WAIT_US clock cycles with `reg_req` low separate the acknowledged command write from the first status request.
- R4: Busy is bit 0 of the status byte. The other bits of the status byte are ignored. Status reads repeat while bit 0 is 1.
- R5: A successful read sets `rd_data` to {high byte, low byte}. `rd_data` changes only in a cycle in which `done` is 1.
- R6: A write issues an address-register write, then the low write register with `wr_data[7:0]`, then the high write register with `wr_data[15:8]`, then status reads until busy is 0. It has no settling wait and no command clear.
- R7: If POLL_MAX status reads in a row all return busy, the block ends with `done` and `err` both 1. It issues no further register operations and leaves `rd_data` unchanged.
- R8: `done` is a one-cycle pulse. It is high in the cycle that follows the edge that completed the last register operation. `err` is 0 on a successful access.
- R9: `start` is ignored while an access is in progress. No extra register operations follow, and the operations already in flight do not change.
- R10: An operation completes on a clock edge where `reg_req` and `reg_ack` are both 1. Until then, `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` stay stable. `reg_rdata` is sampled on that edge.
- R11: The register identifiers are: address 0xD4, command 0xD2, status 0xEA, low write 0xD6, high write 0xD7, low read 0xD8, high read 0xD9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an access (taken only when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| phy_reg | input | 5 | PHY register number |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Word read back |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit exceeded (with done) |
| reg_req | output | 1 | Register operation request |
| reg_we | output | 1 | 1 = register write |
| reg_addr | output | 8 | Register identifier |
| reg_wdata | output | 8 | Register write byte |
| reg_ack | input | 1 | Operation accepted / read byte valid |
| reg_rdata | input | 8 | Register read byte |

## Verification
Every result of this block falls due at a fixed number of cycles after the last operation that the register port acknowledges. The bench uses this in three places. First, it logs the cycle after each completing edge and checks that `done` and `rd_data` are valid in exactly that cycle and that `done` is low one cycle later. Second, it counts the request-free cycles between the command write and the first status read and compares them with WAIT_CYC. Third, it compares the logged operation series entry by entry with a series built from the busy count it programmed into its port model. All sampling happens on the falling clock edge.

// File: rtl/mgmt_seq_pkg.sv
// Shared types and register identifiers for the PHY management sequencer.
// Assumes a byte-wide register port towards the MAC.
package mgmt_seq_pkg;
    localparam int REG_W  = 8;
    localparam int PHY_AW = 5;
    localparam int WORD_W = 2 * REG_W;

    localparam logic [REG_W-1:0] ID_ADR  = 8'hD4;
    localparam logic [REG_W-1:0] ID_CMD  = 8'hD2;
    localparam logic [REG_W-1:0] ID_STAT = 8'hEA;
    localparam logic [REG_W-1:0] ID_WRL  = 8'hD6;
    localparam logic [REG_W-1:0] ID_WRH  = 8'hD7;
    localparam logic [REG_W-1:0] ID_RDL  = 8'hD8;
    localparam logic [REG_W-1:0] ID_RDH  = 8'hD9;

    localparam logic [REG_W-1:0] CMD_READ = 8'h01;
    localparam logic [REG_W-1:0] CMD_IDLE = 8'h00;
    localparam int BUSY_BIT = 0;

    typedef enum logic [3:0] {
        S_IDLE, S_ADR, S_CMD_RD, S_WAIT, S_WR_LO, S_WR_HI,
        S_POLL, S_CMD_CLR, S_GET_HI, S_GET_LO, S_FIN
    } seq_state_t;
endpackage

// File: rtl/mgmt_wait_timer.sv
// Settling timer: after a start pulse, expired is high in the CYCLES-th
// following cycle. Assumes CYCLES >= 1 and no restart while running.
module mgmt_wait_timer #(
    parameter int CYCLES = 2200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign expired = run && (cnt == '0);

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= CW'(CYCLES - 1);
            run <= 1'b1;
        end else if (expired) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R3
    expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/mgmt_poll_limit.sv
// Counts busy status reads of one access. exhausted is high when the
// current busy read would be the LIMIT-th. Assumes LIMIT >= 1.
module mgmt_poll_limit #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic exhausted
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign exhausted = (cnt == CW'(LIMIT - 1));

    // Clear per access, advance on each busy read that is not the last.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (step)       cnt <= cnt + 1'b1;
    end

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/mgmt_word_pack.sv
// Joins two register bytes into a word: the high byte is staged, and the
// word updates only when the low byte arrives.
module mgmt_word_pack #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_hi,
    input  logic          cap_lo,
    input  logic [BW-1:0] byte_in,
    output logic [2*BW-1:0] word_out
);
    logic [BW-1:0] hi_stage;

    // Stage the high byte, publish the whole word with the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage <= '0;
            word_out <= '0;
        end else begin
            if (cap_hi) hi_stage <= byte_in;
            if (cap_lo) word_out <= {hi_stage, byte_in};
        end
    end
endmodule

// File: rtl/mgmt_phy_seq.sv
// PHY management sequencer top. Turns one 16-bit read/write request into
// the series of byte register operations on the MAC management registers.
// Assumes the register port completes an operation when req and ack meet.
module mgmt_phy_seq
    import mgmt_seq_pkg::*;
#(
    parameter int CLK_MHZ  = 200,
    parameter int WAIT_US  = 11,
    parameter int POLL_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [PHY_AW-1:0] phy_reg,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic              reg_req,
    output logic              reg_we,
    output logic [REG_W-1:0]  reg_addr,
    output logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_ack,
    input  logic [REG_W-1:0]  reg_rdata
);
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

    seq_state_t        state, nxt;
    logic              op_wr;
    logic [PHY_AW-1:0] op_reg;
    logic [WORD_W-1:0] op_data;
    logic              err_q;
    logic              xfer, busy_seen, wait_go, wait_end, poll_full;
    logic              take;

    assign xfer      = reg_req && reg_ack;
    assign busy_seen = reg_rdata[BUSY_BIT];
    assign take      = (state == S_IDLE) && start;
    assign wait_go   = (state == S_CMD_RD) && xfer;

    mgmt_wait_timer #(.CYCLES(WAIT_CYC)) u_wait (
        .clk(clk), .rst_n(rst_n), .start(wait_go), .expired(wait_end)
    );

    mgmt_poll_limit #(.LIMIT(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .clear(take),
        .step((state == S_POLL) && xfer && busy_seen && !poll_full),
        .exhausted(poll_full)
    );

    mgmt_word_pack #(.BW(REG_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .cap_hi((state == S_GET_HI) && xfer),
        .cap_lo((state == S_GET_LO) && xfer),
        .byte_in(reg_rdata), .word_out(rd_data)
    );

    // Next-state selection for the access series.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_ADR;
            S_ADR:     if (xfer) nxt = op_wr ? S_WR_LO : S_CMD_RD;
            S_CMD_RD:  if (xfer) nxt = S_WAIT;
            S_WAIT:    if (wait_end) nxt = S_POLL;
            S_WR_LO:   if (xfer) nxt = S_WR_HI;
            S_WR_HI:   if (xfer) nxt = S_POLL;
            S_POLL: begin
                if (xfer) begin
                    if (!busy_seen)    nxt = op_wr ? S_FIN : S_CMD_CLR;
                    else if (poll_full) nxt = S_FIN;
                end
            end
            S_CMD_CLR: if (xfer) nxt = S_GET_HI;
            S_GET_HI:  if (xfer) nxt = S_GET_LO;
            S_GET_LO:  if (xfer) nxt = S_FIN;
            S_FIN:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State register, request capture and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_wr   <= 1'b0;
            op_reg  <= '0;
            op_data <= '0;
            err_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (take) begin
                op_wr   <= wr;
                op_reg  <= phy_reg;
                op_data <= wr_data;
                err_q   <= 1'b0;
            end else if ((state == S_POLL) && xfer && busy_seen && poll_full) begin
                err_q <= 1'b1;
            end
        end
    end

    // Register port drive decoded from the current state.
    always_comb begin
        reg_req   = 1'b1;
        reg_we    = 1'b1;
        reg_addr  = ID_ADR;
        reg_wdata = '0;
        unique case (state)
            S_ADR:     reg_wdata = REG_W'(op_reg);
            S_CMD_RD:  begin reg_addr = ID_CMD; reg_wdata = CMD_READ; end
            S_WR_LO:   begin reg_addr = ID_WRL; reg_wdata = op_data[REG_W-1:0]; end
            S_WR_HI:   begin reg_addr = ID_WRH; reg_wdata = op_data[WORD_W-1:REG_W]; end
            S_POLL:    begin reg_addr = ID_STAT; reg_we = 1'b0; end
            S_CMD_CLR: begin reg_addr = ID_CMD; reg_wdata = CMD_IDLE; end
            S_GET_HI:  begin reg_addr = ID_RDH; reg_we = 1'b0; end
            S_GET_LO:  begin reg_addr = ID_RDL; reg_we = 1'b0; end
            default:   begin reg_req = 1'b0; reg_we = 1'b0; end
        endcase
    end

    assign done = (state == S_FIN);
    assign err  = done && err_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr)
                                   && $stable(reg_we) && $stable(reg_wdata)));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !reg_req);
endmodule

// File: tb/mgmt_phy_seq_tb_top.sv
module mgmt_phy_seq_tb_top;
    localparam int T_MHZ = 200;
    localparam int T_US  = 1;
    localparam int PMAX  = 4;
    localparam int WAITC = T_MHZ * T_US;

    // R11 register identifiers
    localparam logic [7:0] A_ADR = 8'hD4, A_CMD = 8'hD2, A_STAT = 8'hEA;
    localparam logic [7:0] A_WRL = 8'hD6, A_WRH = 8'hD7, A_RDL = 8'hD8, A_RDH = 8'hD9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0;
    logic [4:0] phy = '0;
    logic [15:0] wd = '0;
    logic [15:0] rd_data;
    logic done, err, reg_req, reg_we;
    logic [7:0] reg_addr, reg_wdata;
    logic ack = 1'b0;
    logic [7:0] rresp = '0;

    always #2.5 clk = ~clk;

    mgmt_phy_seq #(.CLK_MHZ(T_MHZ), .WAIT_US(T_US), .POLL_MAX(PMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .phy_reg(phy),
        .wr_data(wd), .rd_data(rd_data), .done(done), .err(err),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(ack), .reg_rdata(rresp)
    );

    int checks = 0, errors = 0;
    int busy_n = 0, txn_id = 0, seen_id = 0, st_cnt = 0;
    int n_ops = 0, cyc = 0, xfer_cyc = 0, gap = 0, gap_last = -1;
    logic gap_arm = 1'b0;
    logic [4:0] cur_phy = '0;
    logic       lw [0:4095];
    logic [7:0] la [0:4095];
    logic [7:0] ld [0:4095];

    function automatic logic [7:0] hi_of(logic [4:0] p);
        return 8'((int'(p) * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] lo_of(logic [4:0] p);
        return {3'b110, p} ^ 8'h5A;
    endfunction

    // Register port model: ack one cycle after a request, log completions.
    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            cyc <= 0;
        end else begin
            cyc <= cyc + 1;
            ack <= reg_req && !ack;
            if (reg_req && !ack) begin
                if (reg_addr == A_STAT) rresp <= (st_cnt < busy_n) ? 8'h81 : 8'h80;
                else if (reg_addr == A_RDH) rresp <= hi_of(cur_phy);
                else if (reg_addr == A_RDL) rresp <= lo_of(cur_phy);
                else rresp <= 8'h3C;
            end
            if (seen_id != txn_id) begin
                seen_id <= txn_id;
                st_cnt  <= 0;
            end else if (reg_req && ack && reg_addr == A_STAT) begin
                st_cnt <= st_cnt + 1;
            end
            if (reg_req && ack) begin
                lw[n_ops] <= reg_we;
                la[n_ops] <= reg_addr;
                ld[n_ops] <= reg_wdata;
                n_ops     <= n_ops + 1;
                xfer_cyc  <= cyc + 1;
                if (reg_we && reg_addr == A_ADR) cur_phy <= reg_wdata[4:0];
            end
            if (reg_req && ack && reg_we && reg_addr == A_CMD && reg_wdata == 8'h01) begin
                gap_arm <= 1'b1;
                gap     <= 0;
            end else if (gap_arm && !reg_req) begin
                gap <= gap + 1;
            end else if (gap_arm && reg_req) begin
                gap_arm  <= 1'b0;
                gap_last <= gap;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    int eidx, emis;
    task automatic expect_op(bit w, logic [7:0] a, logic [7:0] d, bit cd);
        if (eidx >= n_ops || lw[eidx] != w || la[eidx] != a || (cd && ld[eidx] != d))
            emis++;
        eidx++;
    endtask

    task automatic run(bit w, logic [4:0] p, logic [15:0] d, int busy, bit poke);
        int base, np, nexp, t;
        bit ok;
        logic [15:0] prev;
        @(negedge clk);
        base = n_ops;
        prev = rd_data;
        txn_id++;
        busy_n = busy;
        wr = w; phy = p; wd = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            wr = !w; phy = ~p; wd = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk(done, "R8 done seen", int'(done), 1);
        ok = busy < PMAX;
        np = ok ? busy + 1 : PMAX;
        nexp = w ? 3 + np : 2 + np + (ok ? 3 : 0);
        chk(cyc == xfer_cyc, "R8 done timing", cyc, xfer_cyc);
        chk(err == !ok, ok ? "R8 err low" : "R7 err high", int'(err), int'(!ok));
        chk(n_ops - base == nexp, w ? "R6 op count" : "R2 op count", n_ops - base, nexp);
        eidx = base; emis = 0;
        expect_op(1'b1, A_ADR, {3'b000, p}, 1'b1);
        if (w) begin
            expect_op(1'b1, A_WRL, d[7:0], 1'b1);
            expect_op(1'b1, A_WRH, d[15:8], 1'b1);
        end else begin
            expect_op(1'b1, A_CMD, 8'h01, 1'b1);
        end
        for (int i = 0; i < np; i++) expect_op(1'b0, A_STAT, 8'h00, 1'b0);
        if (!w && ok) begin
            expect_op(1'b1, A_CMD, 8'h00, 1'b1);
            expect_op(1'b0, A_RDH, 8'h00, 1'b0);
            expect_op(1'b0, A_RDL, 8'h00, 1'b0);
        end
        chk(emis == 0, w ? "R6 series" : "R2 R4 series", emis, 0);
        if (!w) chk(gap_last == WAITC, "R3 wait", gap_last, WAITC);
        if (!w && ok)
            chk(rd_data == {hi_of(p), lo_of(p)}, "R5 word", rd_data, {hi_of(p), lo_of(p)});
        else
            chk(rd_data == prev, "R7 R5 hold", rd_data, prev);
        @(negedge clk);
        chk(!done, "R8 pulse", int'(done), 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(n_ops - base == nexp, "R9 start ignored", n_ops - base, nexp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!done && !err && !reg_req && rd_data == 16'h0, "R1 reset",
            {done, err, reg_req, rd_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !err && !reg_req && rd_data == 16'h0, "R1 after reset",
            {done, err, reg_req, rd_data}, 0);
        for (int p = 0; p < 32; p++) begin
            run(1'b0, 5'(p), 16'h0, p % 3, 1'b0);
            run(1'b1, 5'(p), 16'((p * 16'h0913) ^ 16'hA55A), p % 4, 1'b0);
        end
        run(1'b0, 5'd9, 16'h0, PMAX, 1'b0);
        run(1'b0, 5'd10, 16'h0, PMAX + 2, 1'b0);
        run(1'b1, 5'd11, 16'hBEEF, PMAX, 1'b0);
        run(1'b0, 5'd3, 16'h0, PMAX - 1, 1'b0);
        run(1'b0, 5'd21, 16'h0, 1, 1'b1);
        run(1'b1, 5'd22, 16'h1234, 2, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule